// File: doc/BRIEF.md
# Byte Stream Start-Code Gate

The block sits in a byte-wide bitstream path, between a fetch engine and two consumers: an embedded processor and a stream-out path to memory. It is armed by a one-cycle `start` pulse. On that pulse it captures a 32-bit control word and a byte limit. It then passes bytes from its input to its output until one of two stop conditions is met. The first stop condition is a match on a programmable three-byte start code. The second is a programmed count of input bytes. When the stream stops, the block raises a `done` strobe together with the final byte and drops `busy`.

Inside the block there are two stages in a fixed order. The start-code matcher sees the raw stream first. The emulation-prevention filter acts after the matcher: it drops a 0x03 byte that immediately follows two zero bytes. Each stage has its own enable bit. Two further control bits choose the destination of the bytes: the processor, stream-out, both, or neither.

Both byte interfaces use valid/ready and have no storage. The output byte is the input byte in the same cycle, and `out_valid` follows `in_valid`. Back-pressure on `out_ready` reaches `in_ready` in the same cycle. A byte that is dropped, or that has no destination, is taken without waiting for `out_ready`. A producer must hold `in_data` stable while `in_valid` is high and `in_ready` is low.

Top module: `scx_stream_gate`

## Requirements
- R1: While reset is asserted, and after it until the first start, `busy`, `in_ready`, `out_valid` and `done` are all 0.
- R2: A `start` pulse captures the control word and `byte_limit`. `busy` is 1 in the cycle after the pulse, except in the case of R12. No byte is taken in the cycle of the pulse itself. A pulse while busy re-arms the block.
- R3: While busy, a kept byte with a destination gives `out_valid` = `in_valid` and `out_data` = `in_data` in the same cycle, and `in_ready` = `out_ready`.
- R4: If neither destination bit is set, bytes are taken with `in_ready` = 1 and `out_valid` = 0.
- R5: `out_to_mem` shows control bit 26 and `out_to_proc` shows control bit 29, both as captured at start.
- R6: Start-code stop applies when the stop mode (bits [28:27]) is 0 and the search bit (24) is set. The pattern is: byte 0 in bits [7:0], byte 1 in bits [15:8], byte 2 in bits [23:16], in stream order. The block stops on the input byte that completes the pattern over three consecutive taken raw bytes. That byte is still forwarded unless R9 drops it. `done` is 1 in the cycle it is taken, and `busy` is 0 from the next cycle.
- R7: A match is found even when it overlaps an earlier partial match. With pattern 00 00 01, the input 00 00 00 01 stops on the fourth byte.
- R8: With stop mode 0 and the search bit clear, no byte stops the stream.
- R9: With bit 25 set, a 0x03 that follows two taken 0x00 bytes is taken but not output. The zero run then restarts, so 00 00 03 03 outputs the second 0x03. The matcher still sees the dropped byte.
- R10: With bit 25 clear, 0x03 bytes are always output.
- R11: With stop mode 1, the block stops on the N-th taken input byte, where N = `byte_limit`. Dropped bytes count toward N. `done` pulses with that byte, and a start code does not stop the stream.
- R12: With stop mode 1 and a limit of 0, `busy` stays 0 after start and no byte is taken.
- R13: Stop modes 2 and 3 never stop the stream.
- R14: Start clears the matcher history and the zero run, so a pattern split across a re-arm is not found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arm pulse; captures ctrl_word and byte_limit |
| ctrl_word | input | 32 | Pattern bytes, stage enables, destinations, stop mode |
| byte_limit | input | CNT_W | Input byte count for stop mode 1 |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte taken when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer can take the output byte |
| out_to_proc | output | 1 | Output byte is meant for the processor |
| out_to_mem | output | 1 | Output byte is meant for stream-out |
| busy | output | 1 | Armed and not yet stopped |
| done | output | 1 | Strobe with the byte that ends the stream |

## Verification
Every byte-path result (`in_ready`, `out_valid`, `out_data`, `done`) is a function of the current inputs and the state captured at earlier edges, so it is due in the cycle the byte is presented. `busy` and the destination flags change one edge after `start`, and `busy` falls one edge after `done`. The bench drives inputs on the falling edge and compares 1 ns later, before the rising edge that takes the byte. It checks `busy` and the flags only after that rising edge has passed. A reference model in the bench steps forward only on the cycles in which it expects a handshake, and it holds a byte across cycles in which it applies back-pressure.

// File: rtl/scx_pkg.sv
package scx_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_LEN = 3;

  typedef enum logic [1:0] {
    STOP_ON_CODE  = 2'd0,
    STOP_ON_COUNT = 2'd1,
    STOP_NEVER_A  = 2'd2,
    STOP_NEVER_B  = 2'd3
  } stop_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] code2;
    logic [BYTE_W-1:0] code1;
    logic [BYTE_W-1:0] code0;
    logic              search_en;
    logic              strip_en;
    logic              mem_en;
    logic              proc_en;
    stop_mode_e        mode;
  } sc_cfg_t;

  function automatic sc_cfg_t decode_ctrl(input logic [31:0] w);
    sc_cfg_t c;
    c.code0     = w[7:0];
    c.code1     = w[15:8];
    c.code2     = w[23:16];
    c.search_en = w[24];
    c.strip_en  = w[25];
    c.mem_en    = w[26];
    c.mode      = stop_mode_e'(w[28:27]);
    c.proc_en   = w[29];
    return c;
  endfunction
endpackage

// File: rtl/scx_code_matcher.sv
module scx_code_matcher #(
  parameter int W      = 8,
  parameter int SC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [SC_LEN*W-1:0] code,
  input  logic [W-1:0]      byte_in,
  input  logic              advance,
  output logic              hit
);
  localparam int HIST = SC_LEN - 1;
  localparam int FW   = $clog2(SC_LEN);

  logic [W-1:0]  hist [HIST];
  logic [FW-1:0] fill;
  logic [SC_LEN-1:0] eq;

  genvar k;
  generate
    for (k = 0; k < HIST; k++) begin : g_cmp
      assign eq[k] = (hist[HIST-1-k] == code[k*W +: W]);
    end
  endgenerate
  assign eq[SC_LEN-1] = (byte_in == code[(SC_LEN-1)*W +: W]);
  assign hit = (fill == FW'(HIST)) && (&eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (clear) begin
      fill <= '0;
    end else if (advance && fill != FW'(HIST)) begin
      fill <= fill + 1'b1;
    end
  end

  generate
    for (k = 0; k < HIST; k++) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist[k] <= '0;
        end else if (clear) begin
          hist[k] <= '0;
        end else if (advance) begin
          if (k == 0) hist[k] <= byte_in;
          else        hist[k] <= hist[(k == 0) ? 0 : k-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/scx_epb_filter.sv
module scx_epb_filter #(
  parameter int W        = 8,
  parameter int ZERO_RUN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         enable,
  input  logic [W-1:0] byte_in,
  input  logic         advance,
  output logic         drop
);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [W-1:0] MARK = W'(3);

  logic [ZW-1:0] zrun;
  logic          run_full;

  assign run_full = (zrun == ZW'(ZERO_RUN));
  assign drop     = enable && run_full && (byte_in == MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
    end else if (clear) begin
      zrun <= '0;
    end else if (advance) begin
      if (drop)                 zrun <= '0;
      else if (byte_in == '0)   zrun <= run_full ? zrun : zrun + 1'b1;
      else                      zrun <= '0;
    end
  end
endmodule

// File: rtl/scx_len_counter.sv
module scx_len_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  input  logic          advance,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = ({1'b0, cnt} + 1'b1) == {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scx_stream_gate.sv
module scx_stream_gate
  import scx_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int ZERO_RUN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       ctrl_word,
  input  logic [CNT_W-1:0]  byte_limit,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              out_to_proc,
  output logic              out_to_mem,
  output logic              busy,
  output logic              done
);
  localparam int CODE_W = CODE_LEN * BYTE_W;

  sc_cfg_t          cfg_d, cfg_q;
  logic [CNT_W-1:0] limit_q;
  logic             run_q;
  logic             live, need, advance, drop, hit, last;
  logic             code_stop, count_stop;
  logic [CODE_W-1:0] code;
  logic             unused_ctrl;

  assign cfg_d       = decode_ctrl(ctrl_word);
  assign unused_ctrl = ^ctrl_word[31:30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      limit_q <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      cfg_q   <= cfg_d;
      limit_q <= byte_limit;
      run_q   <= !(cfg_d.mode == STOP_ON_COUNT && byte_limit == '0);
    end else if (done) begin
      run_q   <= 1'b0;
    end
  end

  assign code = {cfg_q.code2, cfg_q.code1, cfg_q.code0};

  scx_code_matcher #(.W(BYTE_W), .SC_LEN(CODE_LEN)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .code    (code),
    .byte_in (in_data),
    .advance (advance),
    .hit     (hit)
  );

  scx_epb_filter #(.W(BYTE_W), .ZERO_RUN(ZERO_RUN)) u_strip (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .enable  (cfg_q.strip_en),
    .byte_in (in_data),
    .advance (advance),
    .drop    (drop)
  );

  scx_len_counter #(.CW(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .limit   (limit_q),
    .advance (advance),
    .last    (last)
  );

  assign live       = run_q && !start;
  assign need       = cfg_q.mem_en || cfg_q.proc_en;
  assign in_ready   = live && (drop || !need || out_ready);
  assign out_valid  = live && in_valid && !drop && need;
  assign out_data   = in_data;
  assign advance    = in_valid && in_ready;
  assign code_stop  = cfg_q.search_en && (cfg_q.mode == STOP_ON_CODE) && hit;
  assign count_stop = (cfg_q.mode == STOP_ON_COUNT) && last;
  assign done       = advance && (code_stop || count_stop);
  assign busy       = run_q;
  assign out_to_proc = cfg_q.proc_en;
  assign out_to_mem  = cfg_q.mem_en;
endmodule

// File: rtl/scx_stream_gate_chk.sv
module scx_stream_gate_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       mode_in,
  input logic [CNT_W-1:0] byte_limit,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready,
  input logic             out_to_proc,
  input logic             out_to_mem,
  input logic             busy,
  input logic             done
);
  logic [1:0]       c_mode;
  logic [CNT_W-1:0] c_len;
  logic [CNT_W-1:0] c_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mode <= '0;
      c_len  <= '0;
      c_cnt  <= '0;
    end else if (start) begin
      c_mode <= mode_in;
      c_len  <= byte_limit;
      c_cnt  <= '0;
    end else if (in_valid && in_ready) begin
      c_cnt  <= c_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid && !done));

  assert_pass_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && out_data == in_data));

  assert_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_has_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_to_proc || out_to_mem));

  assert_done_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_valid && in_ready));

  assert_stop_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

  assert_count_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_mode == 2'd1) |-> ({1'b0, c_cnt} + 1'b1 == {1'b0, c_len}));

  assert_zero_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && !start && c_mode == 2'd1 && c_len == '0) |-> !busy);
endmodule

bind scx_stream_gate scx_stream_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mode_in     (ctrl_word[28:27]),
  .byte_limit  (byte_limit),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .out_to_proc (out_to_proc),
  .out_to_mem  (out_to_mem),
  .busy        (busy),
  .done        (done)
);

// File: tb/scx_stream_gate_tb.sv
module scx_stream_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] byte_limit = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready, out_to_proc, out_to_mem, busy, done;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scx_stream_gate u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .byte_limit(byte_limit), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .out_to_proc(out_to_proc), .out_to_mem(out_to_mem),
    .busy(busy), .done(done)
  );

  // reference state
  logic       m_run, m_sc, m_epb, m_mem, m_proc;
  logic [1:0] m_mode;
  logic [7:0] m_p0, m_p1, m_p2, m_h0, m_h1;
  int         m_fill, m_zero;
  longint     m_cnt, m_len;

  logic [7:0] stim [14] = '{8'h25, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00,
                           8'h01, 8'h44, 8'h03, 8'h00, 8'h00, 8'h01, 8'h77};

  task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [31:0] w, input logic [31:0] len, input string tag);
    @(negedge clk);
    in_valid = 1'b0; start = 1'b1; ctrl_word = w; byte_limit = len;
    @(negedge clk);
    start = 1'b0;
    m_p0 = w[7:0]; m_p1 = w[15:8]; m_p2 = w[23:16];
    m_sc = w[24]; m_epb = w[25]; m_mem = w[26]; m_mode = w[28:27]; m_proc = w[29];
    m_len = len; m_cnt = 0; m_fill = 0; m_zero = 0; m_h0 = '0; m_h1 = '0;
    m_run = !(m_mode == 2'd1 && len == 0);
    #1;
    chkv({tag, " busy after start"}, busy, m_run);
    chkv("R5 out_to_mem", out_to_mem, m_mem);
    chkv("R5 out_to_proc", out_to_proc, m_proc);
  endtask

  task automatic send(input logic [7:0] b, input bit bp, input string tag);
    for (int k = 0; k < 3; k++) begin
      logic  match, drop, need, e_rdy, e_ov, term;
      string t_rdy, t_ov, t_done;
      @(negedge clk);
      in_valid = 1'b1; in_data = b; out_ready = !(bp && k == 0);
      #1;
      match = (m_fill >= 2) && m_h1 == m_p0 && m_h0 == m_p1 && b == m_p2;
      drop  = m_epb && m_zero >= 2 && b == 8'h03;
      need  = m_mem || m_proc;
      e_rdy = m_run && (drop || !need || out_ready);
      e_ov  = m_run && !drop && need;
      term  = e_rdy && ((m_mode == 2'd0 && m_sc && match) ||
                        (m_mode == 2'd1 && m_cnt + 1 == m_len));
      t_rdy  = drop ? "R9" : (!need ? "R4" : "R3");
      t_ov   = (m_zero >= 2 && b == 8'h03) ? (m_epb ? "R9" : "R10") : (need ? "R3" : "R4");
      t_done = (m_mode == 2'd1) ? "R11" : (m_mode == 2'd0) ? (m_sc ? "R6" : "R8") : "R13";
      if (tag != "") begin t_rdy = tag; t_ov = tag; t_done = tag; end
      chkv({t_rdy, " in_ready"}, in_ready, e_rdy);
      chkv({t_ov, " out_valid"}, out_valid, e_ov);
      if (e_ov) chkv({t_ov, " out_data"}, out_data, b);
      chkv({t_done, " done"}, done, term);
      if (!m_run) break;
      if (e_rdy) begin
        m_h1 = m_h0; m_h0 = b;
        if (m_fill < 2) m_fill++;
        if (drop) m_zero = 0;
        else if (b == 8'h00) m_zero = (m_zero >= 2) ? 2 : m_zero + 1;
        else m_zero = 0;
        m_cnt++;
        if (term) m_run = 1'b0;
        break;
      end
    end
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    out_ready = 1'b1;
    in_valid  = 1'b1;
    repeat (3) @(negedge clk);
    chkv("R1 busy in reset", busy, 0);
    chkv("R1 in_ready in reset", in_ready, 0);
    chkv("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chkv("R1 busy after reset", busy, 0);
    chkv("R1 in_ready after reset", in_ready, 0);
    chkv("R1 done after reset", done, 0);
    in_valid = 1'b0;

    // sweep: every stop mode, every combination of enables and destinations, with and without back-pressure
    for (int mode = 0; mode < 4; mode++) begin
      for (int f = 0; f < 16; f++) begin
        for (int bp = 0; bp < 2; bp++) begin
          logic [31:0] w;
          w = {2'b00, f[3], mode[1:0], f[2], f[1], f[0], 8'h01, 8'h00, 8'h00};
          arm(w, 32'd9, "R2");
          for (int i = 0; i < 14; i++) send(stim[i], bp[0], "");
          idle();
        end
      end
    end

    // R7: overlapping partial match
    arm({2'b01, 2'd0, 1'b1, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd0, "R2");
    send(8'h00, 1'b0, "R7"); send(8'h00, 1'b0, "R7");
    send(8'h00, 1'b0, "R7"); send(8'h01, 1'b0, "R7");
    send(8'h55, 1'b0, "R7");
    idle();

    // R9: matcher sees the byte that removal drops
    arm({2'b01, 2'd0, 1'b1, 1'b1, 1'b1, 8'h03, 8'h00, 8'h00}, 32'd0, "R2");
    send(8'h00, 1'b0, "R9"); send(8'h00, 1'b0, "R9"); send(8'h03, 1'b0, "R9");
    idle();

    // R9: zero run restarts after a removal
    arm({2'b01, 2'd2, 1'b0, 1'b1, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd0, "R2");
    send(8'h00, 1'b1, "R9"); send(8'h00, 1'b1, "R9");
    send(8'h03, 1'b1, "R9"); send(8'h03, 1'b1, "R9");
    idle();

    // R10: removal disabled
    arm({2'b00, 2'd2, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00}, 32'd0, "R2");
    send(8'h00, 1'b0, "R10"); send(8'h00, 1'b0, "R10"); send(8'h03, 1'b0, "R10");
    idle();

    // R12: count mode with a zero limit
    arm({2'b01, 2'd1, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd0, "R12");
    send(8'h11, 1'b0, "R12");
    idle();

    // R11: count of one stops on the first byte
    arm({2'b01, 2'd1, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd1, "R2");
    send(8'h00, 1'b0, "R11"); send(8'h22, 1'b0, "R11");
    idle();

    // R14: re-arm clears the history
    arm({2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd0, "R2");
    send(8'h00, 1'b0, "R14"); send(8'h00, 1'b0, "R14");
    arm({2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00}, 32'd0, "R14");
    send(8'h01, 1'b0, "R14");
    send(8'h00, 1'b0, "R6"); send(8'h00, 1'b0, "R6"); send(8'h01, 1'b0, "R6");
    idle();
    @(negedge clk); #1;
    chkv("R6 busy after stop", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule